// File: doc/BRIEF.md
# Transactional region trace packet generator

This block watches retired-instruction events that mark the edges of transactional regions. It keeps a nesting depth so that it can tell the outermost begin and commit from inner ones. Each time the in-transaction status changes, it emits a short, fixed sequence of trace packets on a valid/ready stream. First comes a mode packet that carries the in-transaction bit and the abort bit. Next comes a packet with the address of the instruction that caused the change. On an abort, a third packet follows with the address where execution resumes, which is the fallback handler.

Events arrive one per cycle on a valid/ready interface. The block lowers its event ready while a packet sequence is still draining, so the packet order always matches the event order. When branch tracing is disabled, the nesting depth is still tracked but no packets are produced. Packets that have already left the block are never withdrawn, including when the transaction later aborts.

Top module: `txn_trace_gen`

## Requirements
- R1: After synchronous active-high reset, `pkt_valid` is 0, `ev_ready` is 1 and the nesting depth is 0.
- R2: A begin event (kind 0) accepted at depth 0 emits a mode packet with payload 1, then a current-address packet (type 1) whose payload is `ev_cur_addr`.
- R3: A begin event accepted at nonzero depth emits nothing and raises the depth by one.
- R4: A commit event (kind 1) at depth 1 emits a mode packet with payload 0, then a current-address packet. A commit at any depth above 1 emits nothing and lowers the depth by one. A commit at depth 0 emits nothing.
- R5: An abort event (kind 2) at nonzero depth emits a mode packet with payload 2, then a current-address packet, then a target-address packet (type 2) carrying `ev_tgt_addr`. It forces the depth to 0 at any depth.
- R6: A lock-elision prefix event that starts no transaction (kind 3) emits nothing and leaves the depth unchanged.
- R7: While `branch_en` is 0, no packets are emitted, but the depth is still updated by every accepted event.
- R8: While `pkt_valid` is 1 and `pkt_ready` is 0, the packet type and payload hold steady. `ev_ready` stays 0 until the last packet of a sequence has been taken.
- R9: Packet type codes are 0 for mode, 1 for current address and 2 for target address. Mode payload bit 0 is the in-transaction bit, bit 1 is the abort bit, and all other bits are 0. Both bits are never 1 together.
- R10: The depth saturates at 2^DEPTH_W-1. A begin at that depth leaves it unchanged.
- R11: An abort event at depth 0 emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be accepted |
| ev_kind | input | 2 | 0 begin, 1 commit, 2 abort, 3 elision prefix without transaction |
| ev_cur_addr | input | ADDR_W | Address of the event's instruction |
| ev_tgt_addr | input | ADDR_W | Address of the next instruction to execute |
| branch_en | input | 1 | Branch tracing enable |
| pkt_valid | output | 1 | Packet present |
| pkt_ready | input | 1 | Downstream takes the packet |
| pkt_type | output | 2 | 0 mode, 1 current address, 2 target address |
| pkt_payload | output | ADDR_W | Mode bits or address |

## Verification
The assertions assume the downstream consumer never drops a packet. They also assume event fields stay stable only while they are offered, so an event counts solely on a cycle where `ev_valid` and `ev_ready` are both high. The stimulus changes inputs only on falling edges. It presents an event until the block accepts it and then withdraws it at once. It keeps `pkt_ready` high except in the backpressure scenario, where it is held low for several cycles mid-sequence. Nesting depths stay within the counter range, apart from the one deliberate saturation run.

// File: rtl/txn_trace_pkg.sv
package txn_trace_pkg;
    typedef enum logic [1:0] {
        EV_BEGIN  = 2'd0,
        EV_COMMIT = 2'd1,
        EV_ABORT  = 2'd2,
        EV_ELIDE  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        PK_MODE = 2'd0,
        PK_CUR  = 2'd1,
        PK_TGT  = 2'd2
    } pkt_type_e;

    typedef enum logic [1:0] {
        TR_NONE   = 2'd0,
        TR_BEGIN  = 2'd1,
        TR_COMMIT = 2'd2,
        TR_ABORT  = 2'd3
    } trans_e;
endpackage

// File: rtl/txn_depth_tracker.sv
module txn_depth_tracker
    import txn_trace_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic [1:0] kind,
    output trans_e     trans_o
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
    } trk_state_t;

    trk_state_t st_d, st_q;
    trans_e     trans;

    always_comb begin
        st_d  = st_q;
        trans = TR_NONE;
        unique case (ev_kind_e'(kind))
            EV_BEGIN: begin
                if (st_q.depth == '0) trans = TR_BEGIN;
                if (st_q.depth != DEPTH_MAX) st_d.depth = st_q.depth + DEPTH_ONE;
            end
            EV_COMMIT: begin
                if (st_q.depth == DEPTH_ONE) trans = TR_COMMIT;
                if (st_q.depth != '0) st_d.depth = st_q.depth - DEPTH_ONE;
            end
            EV_ABORT: begin
                if (st_q.depth != '0) trans = TR_ABORT;
                st_d.depth = '0;
            end
            default: ;
        endcase
        if (!accept) st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign trans_o = trans;

    // R5: an accepted abort leaves no nesting behind
    assert_abort_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == 2'd2) |=> (st_q.depth == '0));

    // R10: the counter never wraps past its top value
    assert_depth_saturates_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == 2'd0 && st_q.depth == DEPTH_MAX) |=> (st_q.depth == DEPTH_MAX));

    // R6: an elision-only prefix leaves the depth alone
    assert_elide_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == 2'd3) |=> $stable(st_q.depth));
endmodule

// File: rtl/txn_pkt_sequencer.sv
module txn_pkt_sequencer
    import txn_trace_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  trans_e            trans,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic              busy,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [1:0]        pkt_type,
    output logic [ADDR_W-1:0] pkt_payload
);
    typedef struct packed {
        logic              busy;
        logic [1:0]        step;
        logic [1:0]        last;
        logic              in_tx;
        logic              aborted;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] tgt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy    = 1'b1;
            st_d.step    = PK_MODE;
            st_d.last    = (trans == TR_ABORT) ? PK_TGT : PK_CUR;
            st_d.in_tx   = (trans == TR_BEGIN);
            st_d.aborted = (trans == TR_ABORT);
            st_d.cur     = cur_addr;
            st_d.tgt     = tgt_addr;
        end else if (st_q.busy && pkt_ready) begin
            if (st_q.step == st_q.last) st_d.busy = 1'b0;
            else                        st_d.step = st_q.step + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (pkt_type_e'(st_q.step))
            PK_MODE: pkt_payload = {{(ADDR_W-2){1'b0}}, st_q.aborted, st_q.in_tx};
            PK_CUR:  pkt_payload = st_q.cur;
            default: pkt_payload = st_q.tgt;
        endcase
    end

    assign busy      = st_q.busy;
    assign pkt_valid = st_q.busy;
    assign pkt_type  = st_q.step;

    // R8: a stalled packet keeps its contents
    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_type) && $stable(pkt_payload)));

    // R8: no new sequence starts on top of one still draining
    assert_no_load_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> !st_q.busy);

    // R9: a mode packet never shows both status bits set
    assert_mode_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_type == 2'd0) |-> !(pkt_payload[1] && pkt_payload[0]));
endmodule

// File: rtl/txn_trace_gen.sv
module txn_trace_gen
    import txn_trace_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_cur_addr,
    input  logic [ADDR_W-1:0] ev_tgt_addr,
    input  logic              branch_en,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [1:0]        pkt_type,
    output logic [ADDR_W-1:0] pkt_payload
);
    logic   seq_busy;
    logic   accept;
    logic   load;
    trans_e trans;

    assign ev_ready = !seq_busy;
    assign accept   = ev_valid && ev_ready;
    assign load     = accept && branch_en && (trans != TR_NONE);

    txn_depth_tracker #(.DEPTH_W(DEPTH_W)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .kind    (ev_kind),
        .trans_o (trans)
    );

    txn_pkt_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .trans       (trans),
        .cur_addr    (ev_cur_addr),
        .tgt_addr    (ev_tgt_addr),
        .busy        (seq_busy),
        .pkt_valid   (pkt_valid),
        .pkt_ready   (pkt_ready),
        .pkt_type    (pkt_type),
        .pkt_payload (pkt_payload)
    );

    // R2: a taken mode packet is always followed by the current-address packet
    assert_mode_then_cur_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && pkt_type == 2'd0) |=> (pkt_valid && pkt_type == 2'd1));

    // R8: events are refused while packets are pending
    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !ev_ready);
endmodule

// File: tb/txn_trace_gen_bench.sv
module txn_trace_gen_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [1:0]    ev_kind = 2'd0;
    logic [AW-1:0] ev_cur_addr = '0;
    logic [AW-1:0] ev_tgt_addr = '0;
    logic          branch_en = 1'b1;
    logic          pkt_valid;
    logic          pkt_ready = 1'b1;
    logic [1:0]    pkt_type;
    logic [AW-1:0] pkt_payload;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txn_trace_gen #(.ADDR_W(AW), .DEPTH_W(4)) u_txn_trace_gen (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_cur_addr(ev_cur_addr), .ev_tgt_addr(ev_tgt_addr),
        .branch_en(branch_en),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_type(pkt_type), .pkt_payload(pkt_payload)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one event from a falling edge until accepted; return on the next falling edge
    task automatic send(input logic [1:0] kind, input logic [AW-1:0] cur, input logic [AW-1:0] tgt);
        ev_kind = kind; ev_cur_addr = cur; ev_tgt_addr = tgt; ev_valid = 1'b1;
        while (!ev_ready) begin
            @(posedge clk); @(negedge clk);
        end
        @(posedge clk); @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_pkt(input logic [1:0] typ, input logic [AW-1:0] pay, input string req);
        chk(pkt_valid === 1'b1, req, 64'(pkt_valid), 64'd1);
        chk(pkt_type === typ, req, 64'(pkt_type), 64'(typ));
        chk(pkt_payload === pay, req, 64'(pkt_payload), 64'(pay));
        @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_none(input string req);
        chk(pkt_valid === 1'b0, req, 64'(pkt_valid), 64'd0);
        @(posedge clk); @(negedge clk);
        chk(pkt_valid === 1'b0, req, 64'(pkt_valid), 64'd0);
    endtask

    task automatic t_reset_R1();
        chk(pkt_valid === 1'b0, "R1 pkt_valid", 64'(pkt_valid), 64'd0);
        chk(ev_ready === 1'b1, "R1 ev_ready", 64'(ev_ready), 64'd1);
    endtask

    task automatic t_nest_commit_R2_R3_R4();
        send(2'd0, 32'h1000, 32'h0);
        expect_pkt(2'd0, 32'd1, "R2 R9 begin mode");
        expect_pkt(2'd1, 32'h1000, "R2 begin cur");
        chk(pkt_valid === 1'b0, "R2 sequence length", 64'(pkt_valid), 64'd0);
        send(2'd0, 32'h1004, 32'h0);
        expect_none("R3 nested begin");
        send(2'd1, 32'h1008, 32'h0);
        expect_none("R4 inner commit");
        send(2'd1, 32'h100C, 32'h0);
        expect_pkt(2'd0, 32'd0, "R4 R9 commit mode");
        expect_pkt(2'd1, 32'h100C, "R4 commit cur");
        send(2'd1, 32'h1010, 32'h0);
        expect_none("R4 commit at depth 0");
    endtask

    task automatic t_abort_R5_R11();
        send(2'd2, 32'h2000, 32'h2100);
        expect_none("R11 abort outside transaction");
        send(2'd0, 32'h2004, 32'h0);
        expect_pkt(2'd0, 32'd1, "R5 begin mode");
        expect_pkt(2'd1, 32'h2004, "R5 begin cur");
        send(2'd0, 32'h2008, 32'h0);
        send(2'd0, 32'h200C, 32'h0);
        expect_none("R3 deep nesting");
        send(2'd2, 32'h2010, 32'h2200);
        expect_pkt(2'd0, 32'd2, "R5 R9 abort mode");
        expect_pkt(2'd1, 32'h2010, "R5 abort cur");
        expect_pkt(2'd2, 32'h2200, "R5 abort tgt");
        chk(pkt_valid === 1'b0, "R5 sequence length", 64'(pkt_valid), 64'd0);
        send(2'd1, 32'h2014, 32'h0);
        expect_none("R5 depth zero after abort");
    endtask

    task automatic t_elide_R6();
        send(2'd3, 32'h3000, 32'h0);
        expect_none("R6 elide outside");
        send(2'd0, 32'h3004, 32'h0);
        expect_pkt(2'd0, 32'd1, "R6 begin mode after elide");
        expect_pkt(2'd1, 32'h3004, "R6 begin cur after elide");
        send(2'd3, 32'h3008, 32'h0);
        expect_none("R6 elide inside");
        send(2'd1, 32'h300C, 32'h0);
        expect_pkt(2'd0, 32'd0, "R6 depth kept commit mode");
        expect_pkt(2'd1, 32'h300C, "R6 depth kept commit cur");
    endtask

    task automatic t_branch_off_R7();
        branch_en = 1'b0;
        send(2'd0, 32'h4000, 32'h0);
        expect_none("R7 begin silenced");
        branch_en = 1'b1;
        send(2'd1, 32'h4004, 32'h0);
        expect_pkt(2'd0, 32'd0, "R7 depth tracked commit mode");
        expect_pkt(2'd1, 32'h4004, "R7 depth tracked commit cur");
    endtask

    task automatic t_backpressure_R8();
        pkt_ready = 1'b0;
        send(2'd0, 32'h5000, 32'h0);
        for (int i = 0; i < 3; i++) begin
            chk(pkt_valid === 1'b1 && pkt_type === 2'd0, "R8 mode held",
                64'({pkt_valid, pkt_type}), 64'({1'b1, 2'd0}));
            chk(pkt_payload === 32'd1, "R8 payload held", 64'(pkt_payload), 64'd1);
            chk(ev_ready === 1'b0, "R8 ev_ready low", 64'(ev_ready), 64'd0);
            @(posedge clk); @(negedge clk);
        end
        pkt_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        pkt_ready = 1'b0;
        chk(pkt_type === 2'd1 && pkt_payload === 32'h5000, "R8 cur after stall",
            64'(pkt_payload), 64'h5000);
        chk(ev_ready === 1'b0, "R8 ev_ready low on last", 64'(ev_ready), 64'd0);
        pkt_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(ev_ready === 1'b1, "R8 ev_ready back", 64'(ev_ready), 64'd1);
        send(2'd2, 32'h5004, 32'h5100);
        expect_pkt(2'd0, 32'd2, "R8 abort mode");
        expect_pkt(2'd1, 32'h5004, "R8 abort cur");
        expect_pkt(2'd2, 32'h5100, "R8 abort tgt");
    endtask

    task automatic t_saturate_R10();
        send(2'd0, 32'h6000, 32'h0);
        expect_pkt(2'd0, 32'd1, "R10 first begin mode");
        expect_pkt(2'd1, 32'h6000, "R10 first begin cur");
        for (int i = 0; i < 15; i++) send(2'd0, 32'h6100, 32'h0);
        expect_none("R10 nested begins silent");
        for (int i = 0; i < 14; i++) begin
            send(2'd1, 32'h6200, 32'h0);
            chk(pkt_valid === 1'b0, "R10 inner commit silent", 64'(pkt_valid), 64'd0);
        end
        send(2'd1, 32'h6300, 32'h0);
        expect_pkt(2'd0, 32'd0, "R10 saturated outer commit mode");
        expect_pkt(2'd1, 32'h6300, "R10 saturated outer commit cur");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_nest_commit_R2_R3_R4();
        t_abort_R5_R11();
        t_elide_R6();
        t_branch_off_R7();
        t_backpressure_R8();
        t_saturate_R10();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule